// File: doc/BRIEF.md
# Four-Bank Interleaved Scratchpad Crossbar

This block gives four independent requesters shared access to one scratchpad memory that is built from four single-port banks. Three requesters are the operand channels of a functional unit (two source streams and one result stream); the fourth is the channel that moves data between the scratchpad and the outside world. Each requester may present one read or one write per cycle. The two lowest address bits pick the bank and the remaining bits pick the row inside that bank, so consecutive addresses fall in consecutive banks and streaming requesters spread naturally across all four.

A per-bank arbiter with rotating priority grants at most one requester per bank per cycle. A requester whose address lands in a bank that nobody else wants this cycle is granted at once, so up to four accesses complete together. A requester that loses sees its ready low and keeps its request presented until granted. Each row is 512 bits (32 lanes of 16 bits) with one write-enable bit per byte. Read data comes back on the requesting port one cycle after acceptance.

Top module: `scpad_xbar`

## Requirements
- R1: Address bits [1:0] select the bank (0 to 3) and bits [ADDR_W-1:2] select the row; data written at an address is read back unchanged from that address on any port.
- R2: In any cycle, at most one port is granted (valid and ready both high) for each bank.
- R3: A valid port whose bank is not targeted by any other valid port in the same cycle has ready high in that cycle.
- R4: Each bank has its own rotating priority, starting at port 0 after reset; after a port k is granted in a bank, port (k+1) mod 4 has highest priority in that bank, then k+2, and so on.
- R5: Ready is never high for a port whose valid is low; a request is accepted in the cycle in which valid and ready are both high.
- R6: An accepted read raises rsp_valid on the same port for exactly the following cycle, with the row data on rsp_rdata; an accepted write or an idle cycle produces no response.
- R7: Write-enable bit i of a port controls data bits [8i+7:8i]; bytes whose enable is low keep their previous content, and a write with all enables low changes nothing.
- R8: While reset is high and in the first cycle after it, rsp_valid is low on every port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Request present, one bit per port |
| req_ready | output | 4 | Request granted this cycle, one bit per port |
| req_we | input | 4 | 1 = write, 0 = read, one bit per port |
| req_addr | input | 4*ADDR_W | Entry address per port, port p at [p*ADDR_W +: ADDR_W] |
| req_wdata | input | 4*512 | Write data per port |
| req_be | input | 4*64 | Byte write enables per port |
| rsp_valid | output | 4 | Read data valid, one bit per port |
| rsp_rdata | output | 4*512 | Read data per port |

## Verification
The hardest state to reach is a bank whose priority pointer has been moved by earlier traffic while several held requests still compete for it, since the winner then depends on history rather than port number. The stimulus keeps every losing request presented unchanged and stacks all four ports, then two ports in reversed order, onto the same bank, with the fill traffic first rotating every pointer to a different position. A bench model of the pointers predicts each grant, and mixed cycles where two ports collide while the other two hit free banks show that a conflict in one bank does not hold back the others.

// File: rtl/scpad_pkg.sv
package scpad_pkg;
  localparam int NBANK  = 4;
  localparam int BSEL_W = $clog2(NBANK);
  localparam int BYTE_W = 8;
endpackage

// File: rtl/scpad_rr_arb.sv
module scpad_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = $clog2(N);

  logic [PW-1:0] ptr;
  logic [PW-1:0] nxt;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && req[PW'(ptr + PW'(i))]) begin
        gnt[PW'(ptr + PW'(i))] = 1'b1;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    nxt = ptr;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) nxt = PW'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (found) ptr <= nxt;
  end
endmodule

// File: rtl/scpad_bank.sv
module scpad_bank #(
  parameter int ROW_W = 8,
  parameter int DW    = 512
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DW-1:0]     wdata,
  input  logic [DW/8-1:0]   be,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int NBYTE = DW / 8;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < NBYTE; i++) begin
          if (be[i]) mem[row][i*8 +: 8] <= wdata[i*8 +: 8];
        end
      end
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/scpad_xbar.sv
module scpad_xbar #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 32,
  parameter int LANE_W = 16,
  localparam int NP    = scpad_pkg::NBANK,
  localparam int DW    = LANES * LANE_W,
  localparam int BW    = DW / scpad_pkg::BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NP-1:0]      req_valid,
  output logic [NP-1:0]      req_ready,
  input  logic [NP-1:0]      req_we,
  input  logic [NP*ADDR_W-1:0] req_addr,
  input  logic [NP*DW-1:0]   req_wdata,
  input  logic [NP*BW-1:0]   req_be,
  output logic [NP-1:0]      rsp_valid,
  output logic [NP*DW-1:0]   rsp_rdata
);
  localparam int NB    = scpad_pkg::NBANK;
  localparam int SW    = scpad_pkg::BSEL_W;
  localparam int ROW_W = ADDR_W - SW;

  logic [SW-1:0] bank_of  [NP];
  logic [SW-1:0] rsp_bank [NP];
  logic [NP-1:0] breq     [NB];
  logic [NP-1:0] bgnt     [NB];
  logic [DW-1:0] bank_q   [NB];

  always_comb begin
    for (int p = 0; p < NP; p++) bank_of[p] = req_addr[p*ADDR_W +: SW];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             m_we;
    logic [ROW_W-1:0] m_row;
    logic [DW-1:0]    m_wd;
    logic [BW-1:0]    m_be;

    always_comb begin
      for (int p = 0; p < NP; p++)
        breq[b][p] = req_valid[p] && (bank_of[p] == SW'(b));
    end

    scpad_rr_arb #(.N(NP)) u_arb (
      .clk (clk),
      .rst (rst),
      .req (breq[b]),
      .gnt (bgnt[b])
    );

    always_comb begin
      m_we  = 1'b0;
      m_row = '0;
      m_wd  = '0;
      m_be  = '0;
      for (int p = 0; p < NP; p++) begin
        if (bgnt[b][p]) begin
          m_we  = req_we[p];
          m_row = req_addr[p*ADDR_W + SW +: ROW_W];
          m_wd  = req_wdata[p*DW +: DW];
          m_be  = req_be[p*BW +: BW];
        end
      end
    end

    scpad_bank #(.ROW_W(ROW_W), .DW(DW)) u_ram (
      .clk   (clk),
      .en    (|bgnt[b]),
      .we    (m_we),
      .row   (m_row),
      .wdata (m_wd),
      .be    (m_be),
      .rdata (bank_q[b])
    );
  end

  always_comb begin
    req_ready = '0;
    for (int b = 0; b < NB; b++) req_ready = req_ready | bgnt[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      for (int p = 0; p < NP; p++) rsp_bank[p] <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        rsp_valid[p] <= req_valid[p] && req_ready[p] && !req_we[p];
        rsp_bank[p]  <= bank_of[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) rsp_rdata[p*DW +: DW] = bank_q[rsp_bank[p]];
  end
endmodule

// File: rtl/scpad_xbar_chk.sv
module scpad_xbar_chk #(
  parameter int ADDR_W = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic [3:0]           req_valid,
  input logic [3:0]           req_ready,
  input logic [3:0]           req_we,
  input logic [4*ADDR_W-1:0]  req_addr,
  input logic [3:0]           rsp_valid
);
  logic [1:0] bk     [4];
  logic [3:0] hit    [4];
  logic [3:0] shared;

  always_comb begin
    for (int p = 0; p < 4; p++) bk[p] = req_addr[p*ADDR_W +: 2];
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 4; p++)
        hit[b][p] = req_valid[p] && req_ready[p] && (bk[p] == 2'(b));
    for (int p = 0; p < 4; p++) begin
      shared[p] = 1'b0;
      for (int q = 0; q < 4; q++)
        if (q != p && req_valid[q] && bk[q] == bk[p]) shared[p] = 1'b1;
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_b
    // R2
    a_r2_one_grant_per_bank: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit[b]));
  end

  for (genvar p = 0; p < 4; p++) begin : g_p
    // R5
    a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
      req_ready[p] |-> req_valid[p]);
    // R3
    a_r3_free_bank_granted: assert property (@(posedge clk) disable iff (rst)
      (req_valid[p] && !shared[p]) |-> req_ready[p]);
    // R6
    a_r6_read_returns: assert property (@(posedge clk) disable iff (rst)
      (req_valid[p] && req_ready[p] && !req_we[p]) |=> rsp_valid[p]);
    // R6
    a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
      !(req_valid[p] && req_ready[p] && !req_we[p]) |=> !rsp_valid[p]);
  end
endmodule

bind scpad_xbar scpad_xbar_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/scpad_xbar_test.sv
module scpad_xbar_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 512;
  localparam int BW = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      req_valid = '0;
  logic [3:0]      req_ready;
  logic [3:0]      req_we = '0;
  logic [4*AW-1:0] req_addr = '0;
  logic [4*DW-1:0] req_wdata = '0;
  logic [4*BW-1:0] req_be = '0;
  logic [3:0]      rsp_valid;
  logic [4*DW-1:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  scpad_xbar #(.ADDR_W(AW)) uut (.*);

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int port; logic [DW-1:0] d; } item_t;
  item_t q[$];

  logic [DW-1:0] model [1 << AW];
  int            bptr  [4];
  logic          pv    [4];
  logic          pwe   [4];
  int            paddr [4];
  logic [DW-1:0] pwd   [4];
  logic [BW-1:0] pbe   [4];

  function automatic logic [DW-1:0] pat(int a, int salt);
    logic [DW-1:0] v;
    for (int l = 0; l < 32; l++) v[l*16 +: 16] = 16'(a * 37 + l * 5 + salt * 911);
    return v;
  endfunction

  task automatic chk(bit ok, string msg, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read results as they fall due
  always @(negedge clk) begin : mon
    logic [3:0]    ev;
    logic [DW-1:0] dd [4];
    ev = '0;
    for (int p = 0; p < 4; p++) dd[p] = '0;
    if (!rst) begin
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        ev[it.port] = 1'b1;
        dd[it.port] = it.d;
      end
      for (int p = 0; p < 4; p++) begin
        if (ev[p] || rsp_valid[p]) begin
          chk(rsp_valid[p] === ev[p], $sformatf("R6 rsp_valid port %0d", p),
              DW'(rsp_valid[p]), DW'(ev[p]));
          if (ev[p])
            chk(rsp_rdata[p*DW +: DW] === dd[p], $sformatf("R1 read data port %0d", p),
                rsp_rdata[p*DW +: DW], dd[p]);
        end
      end
    end
  end

  // driver: presents pending requests for one cycle, predicts grants (R2 R3 R4 R5)
  task automatic step();
    logic [3:0] g;
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      req_valid[p] = pv[p];
      req_we[p]    = pwe[p];
      req_addr[p*AW +: AW] = AW'(paddr[p]);
      req_wdata[p*DW +: DW] = pwd[p];
      req_be[p*BW +: BW] = pbe[p];
    end
    #1;
    g = '0;
    for (int b = 0; b < 4; b++) begin
      bit found = 0;
      for (int i = 0; i < 4; i++) begin
        int idx = (bptr[b] + i) % 4;
        if (!found && pv[idx] && (paddr[idx] % 4) == b) begin
          g[idx] = 1'b1;
          found = 1;
          bptr[b] = (idx + 1) % 4;
        end
      end
    end
    for (int p = 0; p < 4; p++)
      chk(req_ready[p] === g[p], $sformatf("R4 grant port %0d addr %0d", p, paddr[p]),
          DW'(req_ready[p]), DW'(g[p]));
    for (int p = 0; p < 4; p++) begin
      if (g[p]) begin
        if (pwe[p]) begin
          for (int i = 0; i < BW; i++)
            if (pbe[p][i]) model[paddr[p]][i*8 +: 8] = pwd[p][i*8 +: 8];
        end else begin
          item_t it;
          it.due = cyc + 1; it.port = p; it.d = model[paddr[p]];
          q.push_back(it);
        end
        pv[p] = 1'b0;
      end
    end
    @(posedge clk);
  endtask

  task automatic run();
    int guard = 0;
    while ((pv[0] || pv[1] || pv[2] || pv[3]) && guard < 20) begin
      step();
      guard++;
    end
    if (guard >= 20) chk(0, "R5 request never accepted", '0, '1);
  endtask

  task automatic set(int p, bit we, int a, logic [DW-1:0] d, logic [BW-1:0] be);
    pv[p] = 1'b1; pwe[p] = we; paddr[p] = a; pwd[p] = d; pbe[p] = be;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = '0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      pv[p] = 0; pwe[p] = 0; paddr[p] = 0; pwd[p] = '0; pbe[p] = '0; bptr[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 4'b0, "R8 rsp_valid during reset", DW'(rsp_valid), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 4'b0, "R8 rsp_valid after reset", DW'(rsp_valid), '0);

    // R1 R3: fill addresses 0..63, four distinct banks every cycle
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 4; p++) begin
        int a = s * 4 + ((p + s) % 4);
        set(p, 1'b1, a, pat(a, 0), '1);
      end
      run();
    end
    // R1 R6: read back, distinct banks, rotated assignment
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 4; p++) begin
        int a = s * 4 + ((p + s + 1) % 4);
        set(p, 1'b0, a, '0, '0);
      end
      run();
    end
    idle(2);

    // R2 R4: all four ports on bank 0, losers hold their reads
    for (int p = 0; p < 4; p++) set(p, 1'b0, 4 * p + 16, '0, '0);
    run();
    // R4: two ports on bank 2 twice, rotation decides
    set(1, 1'b0, 2, '0, '0); set(2, 1'b0, 6, '0, '0);
    run();
    set(1, 1'b0, 10, '0, '0); set(2, 1'b0, 14, '0, '0);
    run();
    // R2 R3: ports 0 and 1 collide on bank 3, ports 2 and 3 have free banks
    set(0, 1'b0, 3, '0, '0); set(1, 1'b0, 7, '0, '0);
    set(2, 1'b1, 13, pat(13, 5), '1); set(3, 1'b0, 8, '0, '0);
    run();
    idle(1);

    // R7: partial write, then empty-enable write, then read both
    set(3, 1'b1, 5, pat(5, 9), 64'h00FF_F0F0_0000_FFFF);
    set(2, 1'b1, 9, pat(9, 9), 64'h0);
    run();
    set(0, 1'b0, 5, '0, '0); set(1, 1'b0, 9, '0, '0);
    run();
    // R7: write and read on different banks in the same cycle
    set(0, 1'b1, 20, pat(20, 3), 64'hAAAA_AAAA_AAAA_AAAA);
    set(1, 1'b0, 13, '0, '0);
    run();
    set(2, 1'b0, 20, '0, '0);
    run();
    idle(3);
    chk(q.size() == 0, "R6 responses outstanding at end", DW'(q.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule